// File: doc/BRIEF.md
# Serial Peripheral Interface Master with Mode Fault Detection

This block is the master side of a serial peripheral interface. It sends a data word of 1 to 16 bits and receives one of the same length. A register-side strobe loads the transmit word and starts the transfer. The received word is then held until software reads it. The shift direction is chosen at run time. The serial clock rate comes from a power-of-two divisor of the system clock.

Two error conditions are tracked. A mode fault means another device pulled the slave select input low while this block was enabled as a master. It aborts any transfer in progress. An overrun means a word finished while the previous received word was still unread. Both flags are sticky and each has its own clear strobe. A shared error interrupt, gated by an enable, reports either flag. A transfer-complete flag marks the end of each word.

Top module: `spim_top`

## Requirements
- R1: With `cfgEnable`=1 and `cfgMaster`=1, a `txWrite` pulse while idle starts a word of `cfgLen`+1 bits. `ssOut` goes low for the whole word and returns high at its end.
- R2: With `cfgLsbFirst`=0, `mosi` sends transmit bit `cfgLen` first and bit 0 last. With `cfgLsbFirst`=1, it sends bit 0 first and bit `cfgLen` last. Transmit bits above `cfgLen` are never sent.
- R3: `sclk` idles low. Each bit spends 2^`cfgDivSel` system clocks low and then the same number high, so code 0 gives a period of 2 clocks and code 7 a period of 256.
- R4: `miso` is sampled as `sclk` rises. In `rxData` the least significant received bit sits at bit 0 in either shift order, and bits above `cfgLen` read as zero.
- R5: With `cfgFaultEn`=1, a low `ssIn` sets `faultFlag` while the block is an enabled master. The flag stays set until `clrFault`, even if `cfgFaultEn` is cleared afterwards.
- R6: With `cfgFaultEn`=0, the level of `ssIn` has no effect: transfers complete normally and `faultFlag` stays 0.
- R7: A mode fault during a transfer stops it on the next clock edge. `sclk` returns low and `ssOut` high, `rxData` is not updated, and `doneFlag` is not set.
- R8: `doneFlag` is set on the clock edge that ends the last bit's high phase. A `txWrite` clears it.
- R9: A word that completes while the previous received word is unread (no `rxRead` since it arrived) sets `overrunFlag` and is discarded, so `rxData` keeps the old word.
- R10: `errIrq` equals `cfgErrIe` AND (`faultFlag` OR `overrunFlag`). After reset all flags are 0, `ssOut` is 1, `sclk` is 0 and `rxData` is 0.
- R11: `clrFault` clears only `faultFlag`, and `clrOverrun` clears only `overrunFlag`.
- R12: `mosi` changes only while `sclk` is low, so it is stable at every rising edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Block enable |
| cfgMaster | input | 1 | Master select |
| cfgLsbFirst | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| cfgErrIe | input | 1 | Error interrupt enable |
| cfgFaultEn | input | 1 | Mode fault detection enable |
| cfgDivSel | input | 3 | Divisor select; serial clock period is 2^(code+1) clocks |
| cfgLen | input | 4 | Word length minus one |
| txWrite | input | 1 | Transmit write strobe; starts a transfer if idle |
| txData | input | 16 | Transmit word, right-justified |
| rxRead | input | 1 | Receive read strobe; marks the held word as consumed |
| rxData | output | 16 | Received word, right-justified and zero-padded |
| clrFault | input | 1 | Clears the mode fault flag |
| clrOverrun | input | 1 | Clears the overrun flag |
| doneFlag | output | 1 | Transfer complete |
| faultFlag | output | 1 | Mode fault flag |
| overrunFlag | output | 1 | Overrun flag |
| errIrq | output | 1 | Error interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ssOut | output | 1 | Slave select out, active low |
| miso | input | 1 | Serial data in |
| ssIn | input | 1 | Slave select in, active low, used for fault detection |

## Verification
A wrong bit counter or a wrong position index shows on `mosi` within the first word. It appears as a reversed or truncated sequence, or a wrong number of `sclk` pulses before `ssOut` rises. A wrong divider count shows as a wrong spacing between `sclk` rising edges. Errors in the receive-full tracking appear only on the second unread word, as a missing overrun flag or an overwritten `rxData`. A fault path that fails to abort leaves `ssOut` low one clock after `ssIn` falls.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 16;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic             active;
    logic             start;
    logic             sample;
    logic             finish;
    logic             abort;
    logic             setFault;
    logic [IDX_W-1:0] bitIdx;
    logic [IDX_W-1:0] lastIdx;
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          master,
  input  logic          faultEn,
  input  logic [SW-1:0] divSel,
  input  logic [IW-1:0] len,
  input  logic          txWrite,
  input  logic          ssIn,
  output spimStrobe_t   st,
  output logic          sclk,
  output logic          ssOut
);
  localparam int HALF_W = (1 << SW) - 1;

  logic              busy;
  logic              sclkR;
  logic [HALF_W-1:0] divCnt;
  logic [HALF_W-1:0] halfMax;
  logic [SW-1:0]     divQ;
  logic [IW-1:0]     bitCnt;
  logic [IW-1:0]     lenQ;
  logic              faultCond;
  logic              tick;

  assign faultCond = enable & master & faultEn & ~ssIn;
  assign halfMax   = HALF_W'((32'd1 << divQ) - 32'd1);
  assign tick      = busy && (divCnt == halfMax);

  always_comb begin
    st          = '0;
    st.active   = busy;
    st.start    = txWrite && enable && master && !busy && !faultCond;
    st.abort    = busy && faultCond;
    st.sample   = tick && !sclkR && !faultCond;
    st.finish   = tick && sclkR && (bitCnt == lenQ) && !faultCond;
    st.setFault = faultCond;
    st.bitIdx   = bitCnt;
    st.lastIdx  = lenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sclkR  <= 1'b0;
      divCnt <= '0;
      divQ   <= '0;
      bitCnt <= '0;
      lenQ   <= '0;
    end else if (st.start) begin
      busy   <= 1'b1;
      sclkR  <= 1'b0;
      divCnt <= '0;
      divQ   <= divSel;
      bitCnt <= '0;
      lenQ   <= len;
    end else if (st.abort) begin
      busy   <= 1'b0;
      sclkR  <= 1'b0;
      divCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        sclkR  <= ~sclkR;
        if (st.finish) busy <= 1'b0;
        else if (sclkR) bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sclk  = sclkR;
  assign ssOut = ~busy;

  a_r12_sclk_only_in_word: assert property (@(posedge clk) disable iff (!rstN)
    sclkR |-> busy);
  a_r7_abort_idles: assert property (@(posedge clk) disable iff (!rstN)
    st.abort |=> (!busy && !sclkR));
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (divCnt <= halfMax));
  a_r1_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= lenQ));
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  spimStrobe_t   st,
  input  logic          lsbFirst,
  input  logic          txWrite,
  input  logic [DW-1:0] txData,
  input  logic          rxRead,
  input  logic          miso,
  input  logic          clrFault,
  input  logic          clrOverrun,
  input  logic          errIe,
  output logic          mosi,
  output logic [DW-1:0] rxData,
  output logic          doneFlag,
  output logic          faultFlag,
  output logic          overrunFlag,
  output logic          errIrq
);
  logic [DW-1:0] txHold;
  logic [DW-1:0] rxAcc;
  logic [DW-1:0] rxReg;
  logic          rxFull;
  logic          lsbQ;
  logic [IW-1:0] pos;

  assign pos  = lsbQ ? st.bitIdx : (st.lastIdx - st.bitIdx);
  assign mosi = st.active ? txHold[pos] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      rxAcc  <= '0;
      lsbQ   <= 1'b0;
    end else if (st.start) begin
      txHold <= txData;
      rxAcc  <= '0;
      lsbQ   <= lsbFirst;
    end else if (st.sample) begin
      rxAcc[pos] <= miso;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg       <= '0;
      rxFull      <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      if (st.finish && rxFull && !rxRead) begin
        if (!clrOverrun) overrunFlag <= 1'b1;
      end else if (st.finish) begin
        rxReg  <= rxAcc;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end
      if (clrOverrun) overrunFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag  <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      if (st.finish) doneFlag <= 1'b1;
      else if (txWrite) doneFlag <= 1'b0;
      if (clrFault) faultFlag <= 1'b0;
      else if (st.setFault) faultFlag <= 1'b1;
    end
  end

  assign rxData = rxReg;
  assign errIrq = errIe & (faultFlag | overrunFlag);

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clrFault) |=> faultFlag);
  a_r9_discard_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && rxFull && !rxRead) |=> $stable(rxData));
  a_r8_done_after_finish: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> doneFlag);
  a_r7_abort_no_update: assert property (@(posedge clk) disable iff (!rstN)
    st.abort |=> $stable(rxData));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic              cfgLsbFirst,
  input  logic              cfgErrIe,
  input  logic              cfgFaultEn,
  input  logic [SEL_W-1:0]  cfgDivSel,
  input  logic [IDX_W-1:0]  cfgLen,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  input  logic              clrFault,
  input  logic              clrOverrun,
  output logic              doneFlag,
  output logic              faultFlag,
  output logic              overrunFlag,
  output logic              errIrq,
  output logic              sclk,
  output logic              mosi,
  output logic              ssOut,
  input  logic              miso,
  input  logic              ssIn
);
  spimStrobe_t st;

  spim_ctrl #(.SW(SEL_W), .IW(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(cfgEnable), .master(cfgMaster),
    .faultEn(cfgFaultEn), .divSel(cfgDivSel), .len(cfgLen),
    .txWrite(txWrite), .ssIn(ssIn), .st(st), .sclk(sclk), .ssOut(ssOut)
  );

  spim_dp #(.DW(DATA_W), .IW(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .lsbFirst(cfgLsbFirst),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .miso(miso),
    .clrFault(clrFault), .clrOverrun(clrOverrun), .errIe(cfgErrIe),
    .mosi(mosi), .rxData(rxData), .doneFlag(doneFlag),
    .faultFlag(faultFlag), .overrunFlag(overrunFlag), .errIrq(errIrq)
  );
endmodule

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b1, cfgMaster = 1'b1, cfgLsbFirst = 1'b0;
  logic cfgErrIe = 1'b0, cfgFaultEn = 1'b0;
  logic [2:0] cfgDivSel = '0;
  logic [3:0] cfgLen = '0;
  logic txWrite = 1'b0, rxRead = 1'b0, clrFault = 1'b0, clrOverrun = 1'b0;
  logic [15:0] txData = '0;
  logic miso = 1'b0, ssIn = 1'b1;
  logic [15:0] rxData;
  logic doneFlag, faultFlag, overrunFlag, errIrq, sclk, mosi, ssOut;

  always #5 clk = ~clk;

  spim_top u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgLsbFirst(cfgLsbFirst), .cfgErrIe(cfgErrIe), .cfgFaultEn(cfgFaultEn),
    .cfgDivSel(cfgDivSel), .cfgLen(cfgLen), .txWrite(txWrite), .txData(txData),
    .rxRead(rxRead), .rxData(rxData), .clrFault(clrFault), .clrOverrun(clrOverrun),
    .doneFlag(doneFlag), .faultFlag(faultFlag), .overrunFlag(overrunFlag),
    .errIrq(errIrq), .sclk(sclk), .mosi(mosi), .ssOut(ssOut), .miso(miso), .ssIn(ssIn)
  );

  typedef struct {
    int          nBits;
    logic [15:0] seq;
    int          period;
    bit          isAbort;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0, mismatched = 0;
  logic [15:0] slaveSeq = '0;
  int slaveN = 1;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rev(input logic [15:0] v, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [15:0] lowBits(input logic [15:0] v, input int n);
    return (n >= 16) ? v : (v & ((16'd1 << n) - 16'd1));
  endfunction

  // monitor: collects mosi at each sclk rise and compares against the queue
  initial begin
    forever begin
      int cnt;
      logic [15:0] val;
      time lastT;
      bit perOk;
      expItem_t e;
      @(negedge ssOut);
      cnt = 0; val = '0; lastT = 0; perOk = 1;
      while (1) begin
        @(posedge sclk or posedge ssOut);
        if (ssOut) break;
        if (!sclk) continue;
        if (cnt > 0 && e.period != 0 && ($time - lastT) != 0) begin
          if (expQ.size() > 0 && ($time - lastT) != time'(expQ[0].period * 10)) perOk = 0;
        end
        lastT = $time;
        val = {val[14:0], mosi};
        cnt++;
      end
      if (expQ.size() == 0) begin
        chk(0, "R1 unexpected word", cnt, 0);
      end else begin
        e = expQ.pop_front();
        if (e.isAbort) begin
          chk(cnt < e.nBits, "R7 aborted word length", cnt, e.nBits);
        end else begin
          chk(cnt == e.nBits, "R1 bit count", cnt, e.nBits);
          chk(val == e.seq, "R2 mosi sequence", val, e.seq);
          chk(perOk, "R3 sclk period", 0, e.period);
        end
      end
    end
  end

  // slave model: drives miso in order, changing on sclk falling edges
  initial begin
    forever begin
      int k;
      @(negedge ssOut);
      k = 0;
      miso = slaveSeq[slaveN-1];
      while (1) begin
        @(negedge sclk or posedge ssOut);
        if (ssOut) break;
        k++;
        if (k < slaveN) miso = slaveSeq[slaveN-1-k];
      end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // driver: configures, pushes the expectation, starts the word
  task automatic startWord(input int n, input bit lsb, input int sel,
                           input logic [15:0] tx, input logic [15:0] sSeq, input bit ab);
    expItem_t e;
    @(negedge clk);
    cfgLen = 4'(n - 1); cfgLsbFirst = lsb; cfgDivSel = 3'(sel);
    txData = tx; slaveSeq = sSeq; slaveN = n;
    e.nBits = n; e.period = 2 << sel; e.isAbort = ab;
    e.seq = lsb ? rev(lowBits(tx, n), n) : lowBits(tx, n);
    expQ.push_back(e);
    txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (!ssOut && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic runWord(input int n, input bit lsb, input int sel,
                         input logic [15:0] tx, input logic [15:0] sSeq);
    startWord(n, lsb, sel, tx, sSeq, 0);
    chk(doneFlag == 0, "R8 done cleared by write", doneFlag, 0);
    chk(ssOut == 0, "R1 ssOut low in word", ssOut, 0);
    waitIdle();
    chk(doneFlag == 1, "R8 done after word", doneFlag, 1);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ssOut == 1 && sclk == 0, "R10 reset serial idle", {ssOut, sclk}, 2);
    chk({doneFlag, faultFlag, overrunFlag, errIrq} == 0, "R10 reset flags",
        {doneFlag, faultFlag, overrunFlag, errIrq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R4 msb-first 8 bits, divide by 2
    runWord(8, 0, 0, 16'h3CA5, 16'h0096);
    chk(rxData == 16'h0096, "R4 rx msb-first", rxData, 16'h0096);
    pulse(rxRead);
    // lsb-first 8 bits, divide by 4
    runWord(8, 1, 1, 16'h0001, 16'h00C1);
    chk(rxData == rev(16'h00C1, 8), "R4 rx lsb-first", rxData, rev(16'h00C1, 8));
    pulse(rxRead);
    // full 16 bits, divide by 256
    runWord(16, 0, 7, 16'h8001, 16'h1234);
    chk(rxData == 16'h1234, "R4 rx 16-bit", rxData, 16'h1234);
    pulse(rxRead);
    // single bit lsb-first, divide by 8
    runWord(1, 1, 2, 16'hFFFF, 16'h0001);
    chk(rxData == 16'h0001, "R4 rx 1-bit", rxData, 16'h0001);
    pulse(rxRead);

    // R9 overrun: two 5-bit words, first left unread
    runWord(5, 0, 0, 16'hFFF3, 16'h0015);
    chk(rxData == 16'h0015, "R4 rx 5-bit zero padded", rxData, 16'h0015);
    runWord(5, 0, 0, 16'h0002, 16'h000A);
    chk(overrunFlag == 1, "R9 overrun set", overrunFlag, 1);
    chk(rxData == 16'h0015, "R9 old word kept", rxData, 16'h0015);
    chk(errIrq == 0, "R10 irq masked", errIrq, 0);
    cfgErrIe = 1'b1; @(negedge clk);
    chk(errIrq == 1, "R10 irq on overrun", errIrq, 1);
    pulse(clrFault);
    chk(overrunFlag == 1, "R11 clrFault leaves overrun", overrunFlag, 1);
    pulse(clrOverrun);
    chk(overrunFlag == 0 && errIrq == 0, "R11 overrun cleared", {overrunFlag, errIrq}, 0);
    pulse(rxRead);

    // R6 fault detection disabled: ssIn low has no effect
    startWord(8, 0, 1, 16'h005A, 16'h0033, 0);
    repeat (6) @(negedge clk);
    ssIn = 1'b0;
    waitIdle();
    chk(doneFlag == 1 && faultFlag == 0, "R6 word completes", {doneFlag, faultFlag}, 2);
    chk(rxData == 16'h0033, "R6 rx received", rxData, 16'h0033);
    ssIn = 1'b1;
    pulse(rxRead);

    // R7 R5 fault abort
    cfgFaultEn = 1'b1;
    startWord(16, 0, 3, 16'hBEEF, 16'hFFFF, 1);
    repeat (40) @(negedge clk);
    ssIn = 1'b0;
    @(negedge clk);
    chk(ssOut == 1 && sclk == 0, "R7 abort idles serial side", {ssOut, sclk}, 2);
    chk(faultFlag == 1, "R5 fault set", faultFlag, 1);
    chk(doneFlag == 0, "R7 done not set", doneFlag, 0);
    chk(rxData == 16'h0033, "R7 rx not updated", rxData, 16'h0033);
    chk(errIrq == 1, "R10 irq on fault", errIrq, 1);
    ssIn = 1'b1; cfgFaultEn = 1'b0;
    repeat (3) @(negedge clk);
    chk(faultFlag == 1, "R5 fault sticky after enable off", faultFlag, 1);
    pulse(clrOverrun);
    chk(faultFlag == 1, "R11 clrOverrun leaves fault", faultFlag, 1);
    pulse(clrFault);
    chk(faultFlag == 0 && errIrq == 0, "R11 fault cleared", {faultFlag, errIrq}, 0);

    // R12 recovery word after fault, lsb-first
    runWord(12, 1, 0, 16'h0ABC, 16'h0F0F);
    chk(rxData == rev(16'h0F0F, 12), "R12 rx after recovery", rxData, rev(16'h0F0F, 12));
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R1 all words seen", expQ.size(), 0);
    finishRun();
  end
endmodule